// File: doc/BRIEF.md
# Byte-Addressed Register Access Controller

This block is the function-command layer of a serial slave that sits behind a single-wire bit interface. Once the address layer has selected the slave, it takes one command byte and then an 8-bit start address. After that it streams data bytes out to the master or takes them in. Every byte moves one bit per bit-slot event, least significant bit first. The address steps by one after every complete byte and rolls over from FFh to 00h.

The block keeps the status register and the pin-control register itself. It sees the live current measurement and the live accumulator value through read ports. It hands a new 16-bit accumulator value to the measurement logic through a write port with a one-cycle strobe. Reading the high byte of a two-byte register freezes both halves for the rest of that read command, so a background update cannot split the pair. A bus reset ends any command at any bit, and a byte left half-written is dropped.

Top module: `regAccessCtl`

## Requirements
- R1: The command byte 69h starts a read and 6Ch starts a write. Command, address and data bits all travel least significant bit first. Any other command byte leaves the block idle until the next selection: bitOut stays 0 and no register changes.
- R2: The first data bit is exchanged in the slot right after the eighth address bit. The address increments after every complete data byte and wraps from FFh to 00h.
- R3: Read values by address. 01h is the status register (bit 6 sleep enable, bit 4 alternate opcode, other bits 0). 08h returns the pin level in bit 6 with other bits 0. 0Eh/0Fh return the current value high/low byte. 10h/11h return the accumulator high/low byte. Every other address reads 00h.
- R4: Reading 0Eh captures the full 16-bit current value, and reading 10h captures the full accumulator. A later read of 0Fh or 11h in the same command returns the captured low byte. Without a preceding high-byte read in the same command, the live low byte is returned.
- R5: A complete byte written to 01h sets sleepEn from bit 6 and altOpSel from bit 4. Both are 0 after reset.
- R6: A complete byte written to 08h with bit 6 = 0 turns pullDownEn on, and bit 6 = 1 turns it off. After reset it is off.
- R7: A byte written to 10h is held. A byte written to 11h drives accWrData = {held high byte, low byte} and pulses accWrStb for exactly one cycle.
- R8: Writes to 0Eh, 0Fh and reserved addresses change no output and raise no strobe.
- R9: busReset ends a command at any bit boundary. A partially received write byte is discarded, and the next selection starts cleanly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| busReset | input | 1 | Bus reset seen by the bit layer; aborts the command |
| selDone | input | 1 | One-cycle pulse: the slave was selected, a command byte follows |
| bitValid | input | 1 | One-cycle pulse per bit slot |
| bitIn | input | 1 | Bit written by the master in the current slot |
| bitOut | output | 1 | Bit the slave presents for the current read slot |
| curValue | input | 16 | Live current measurement |
| accValue | input | 16 | Live accumulator value |
| accWrData | output | 16 | New accumulator value |
| accWrStb | output | 1 | One-cycle strobe: load accWrData |
| pinLevel | input | 1 | Actual level of the controlled pin |
| pullDownEn | output | 1 | Enables the open-drain pull-down |
| sleepEn | output | 1 | Permits sleep on a long-low bus |
| altOpSel | output | 1 | Selects the alternate read-address opcode |

## Verification
The bench builds the block with its default parameters: 8-bit bytes, an 8-bit address and the default map addresses. With these values the FFh-to-00h wrap is reached after only a few bytes of a command started at FFh. A behavioural model tracks the register contents and the captured pairs. The bench compares the model against the outputs every clock and against bitOut in every read slot. Between the bytes of a pair read it changes the live measurement and accumulator values, so that capture and the live low byte can both be told apart.

// File: rtl/regAccPkg.sv
`timescale 1ns/1ps
package regAccPkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 8;
  localparam int PAIR_W = 2 * BYTE_W;
  localparam int CNT_W  = $clog2(BYTE_W);

  localparam logic [BYTE_W-1:0] OP_READ  = 8'h69;
  localparam logic [BYTE_W-1:0] OP_WRITE = 8'h6C;

  localparam int SLEEP_BIT = 6;
  localparam int ALTOP_BIT = 4;
  localparam int PIN_BIT   = 6;

  typedef struct packed {
    logic addrShift;
    logic dataShift;
    logic byteCommit;
    logic addrInc;
    logic clearHold;
    logic rdActive;
  } ctlStrb_t;
endpackage

// File: rtl/regAccCtl.sv
`timescale 1ns/1ps
module regAccCtl
  import regAccPkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             busReset,
  input  logic             selDone,
  input  logic             bitValid,
  input  logic             bitIn,
  output ctlStrb_t         strb,
  output logic [CNT_W-1:0] bitIdx
);
  typedef enum logic [2:0] {S_IDLE, S_CMD, S_ADDR, S_RD, S_WR} ctlState_t;

  localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);

  ctlState_t          state;
  logic [BYTE_W-1:0]  cmdSr;
  logic [BYTE_W-1:0]  nextCmd;
  logic               isWrite;
  logic               bitGo;
  logic               lastBit;

  assign nextCmd = {bitIn, cmdSr[BYTE_W-1:1]};
  assign bitGo   = bitValid && !busReset && !selDone;
  assign lastBit = (bitIdx == LAST);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_IDLE;
      bitIdx  <= '0;
      cmdSr   <= '0;
      isWrite <= 1'b0;
    end else if (busReset) begin
      state  <= S_IDLE;
      bitIdx <= '0;
    end else if (selDone) begin
      state  <= S_CMD;
      bitIdx <= '0;
    end else if (bitValid) begin
      case (state)
        S_CMD: begin
          cmdSr  <= nextCmd;
          bitIdx <= bitIdx + 1'b1;
          if (lastBit) begin
            if (nextCmd == OP_READ) begin
              state   <= S_ADDR;
              isWrite <= 1'b0;
            end else if (nextCmd == OP_WRITE) begin
              state   <= S_ADDR;
              isWrite <= 1'b1;
            end else begin
              state <= S_IDLE;
            end
          end
        end
        S_ADDR: begin
          bitIdx <= bitIdx + 1'b1;
          if (lastBit) state <= isWrite ? S_WR : S_RD;
        end
        S_RD, S_WR: bitIdx <= bitIdx + 1'b1;
        default: ;
      endcase
    end
  end

  always_comb begin
    strb            = '0;
    strb.addrShift  = bitGo && (state == S_ADDR);
    strb.dataShift  = bitGo && (state == S_WR);
    strb.byteCommit = bitGo && (state == S_WR) && lastBit;
    strb.addrInc    = bitGo && ((state == S_RD) || (state == S_WR)) && lastBit;
    strb.clearHold  = selDone && !busReset;
    strb.rdActive   = (state == S_RD);
  end

  assert_reset_idle_R9: assert property (@(posedge clk) disable iff (!rstN)
    busReset |=> (state == S_IDLE) && (bitIdx == '0));

  assert_read_continues_R2: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_RD && bitGo && lastBit) |=> (state == S_RD) && (bitIdx == '0));

  assert_bad_cmd_idle_R1: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_CMD && bitGo && lastBit && nextCmd != OP_READ && nextCmd != OP_WRITE)
      |=> (state == S_IDLE));
endmodule

// File: rtl/regAccData.sv
`timescale 1ns/1ps
module regAccData
  import regAccPkg::*;
#(
  parameter logic [ADDR_W-1:0] STAT_ADDR   = 8'h01,
  parameter logic [ADDR_W-1:0] PINC_ADDR   = 8'h08,
  parameter logic [ADDR_W-1:0] CUR_HI_ADDR = 8'h0E,
  parameter logic [ADDR_W-1:0] CUR_LO_ADDR = 8'h0F,
  parameter logic [ADDR_W-1:0] ACC_HI_ADDR = 8'h10,
  parameter logic [ADDR_W-1:0] ACC_LO_ADDR = 8'h11
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrb_t          strb,
  input  logic [CNT_W-1:0]  bitIdx,
  input  logic              bitIn,
  input  logic [PAIR_W-1:0] curValue,
  input  logic [PAIR_W-1:0] accValue,
  input  logic              pinLevel,
  output logic              bitOut,
  output logic              sleepEn,
  output logic              altOpSel,
  output logic              pullDownEn,
  output logic [PAIR_W-1:0] accWrData,
  output logic              accWrStb
);
  logic [ADDR_W-1:0] addr;
  logic [BYTE_W-1:0] rxSr;
  logic [BYTE_W-1:0] wrByte;
  logic [BYTE_W-1:0] accHi;
  logic [PAIR_W-1:0] curHold;
  logic [PAIR_W-1:0] accHold;
  logic              curHeld;
  logic              accHeld;
  logic [BYTE_W-1:0] rdByte;
  logic [PAIR_W-1:0] curView;
  logic [PAIR_W-1:0] accView;

  assign wrByte  = {bitIn, rxSr[BYTE_W-1:1]};
  assign curView = curHeld ? curHold : curValue;
  assign accView = accHeld ? accHold : accValue;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addr       <= '0;
      rxSr       <= '0;
      sleepEn    <= 1'b0;
      altOpSel   <= 1'b0;
      pullDownEn <= 1'b0;
      accHi      <= '0;
      accWrData  <= '0;
      accWrStb   <= 1'b0;
    end else begin
      accWrStb <= 1'b0;
      if (strb.addrShift) addr <= {bitIn, addr[ADDR_W-1:1]};
      if (strb.dataShift) rxSr <= wrByte;
      if (strb.addrInc)   addr <= addr + 1'b1;
      if (strb.byteCommit) begin
        case (addr)
          STAT_ADDR: begin
            sleepEn  <= wrByte[SLEEP_BIT];
            altOpSel <= wrByte[ALTOP_BIT];
          end
          PINC_ADDR:   pullDownEn <= ~wrByte[PIN_BIT];
          ACC_HI_ADDR: accHi <= wrByte;
          ACC_LO_ADDR: begin
            accWrData <= {accHi, wrByte};
            accWrStb  <= 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curHeld <= 1'b0;
      accHeld <= 1'b0;
      curHold <= '0;
      accHold <= '0;
    end else if (strb.clearHold) begin
      curHeld <= 1'b0;
      accHeld <= 1'b0;
    end else if (strb.rdActive) begin
      if (addr == CUR_HI_ADDR && !curHeld) begin
        curHold <= curValue;
        curHeld <= 1'b1;
      end
      if (addr == ACC_HI_ADDR && !accHeld) begin
        accHold <= accValue;
        accHeld <= 1'b1;
      end
    end
  end

  always_comb begin
    rdByte = '0;
    case (addr)
      STAT_ADDR: begin
        rdByte[SLEEP_BIT] = sleepEn;
        rdByte[ALTOP_BIT] = altOpSel;
      end
      PINC_ADDR:   rdByte[PIN_BIT] = pinLevel;
      CUR_HI_ADDR: rdByte = curView[PAIR_W-1:BYTE_W];
      CUR_LO_ADDR: rdByte = curView[BYTE_W-1:0];
      ACC_HI_ADDR: rdByte = accView[PAIR_W-1:BYTE_W];
      ACC_LO_ADDR: rdByte = accView[BYTE_W-1:0];
      default:     rdByte = '0;
    endcase
  end

  assign bitOut = strb.rdActive & rdByte[bitIdx];

  assert_strobe_single_R7: assert property (@(posedge clk) disable iff (!rstN)
    accWrStb |=> !accWrStb);

  assert_status_quiet_R5: assert property (@(posedge clk) disable iff (!rstN)
    !strb.byteCommit |=> $stable(sleepEn) && $stable(altOpSel) && $stable(pullDownEn));

  assert_hold_stable_R4: assert property (@(posedge clk) disable iff (!rstN)
    (curHeld && !strb.clearHold) |=> curHeld && $stable(curHold));

  assert_addr_step_R2: assert property (@(posedge clk) disable iff (!rstN)
    strb.addrInc |=> (addr == $past(addr) + 1'b1));

  assert_ro_no_strobe_R8: assert property (@(posedge clk) disable iff (!rstN)
    (strb.byteCommit && addr != ACC_LO_ADDR) |=> !accWrStb);
endmodule

// File: rtl/regAccessCtl.sv
`timescale 1ns/1ps
module regAccessCtl
  import regAccPkg::*;
#(
  parameter logic [ADDR_W-1:0] STAT_ADDR   = 8'h01,
  parameter logic [ADDR_W-1:0] PINC_ADDR   = 8'h08,
  parameter logic [ADDR_W-1:0] CUR_HI_ADDR = 8'h0E,
  parameter logic [ADDR_W-1:0] CUR_LO_ADDR = 8'h0F,
  parameter logic [ADDR_W-1:0] ACC_HI_ADDR = 8'h10,
  parameter logic [ADDR_W-1:0] ACC_LO_ADDR = 8'h11
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busReset,
  input  logic              selDone,
  input  logic              bitValid,
  input  logic              bitIn,
  output logic              bitOut,
  input  logic [PAIR_W-1:0] curValue,
  input  logic [PAIR_W-1:0] accValue,
  output logic [PAIR_W-1:0] accWrData,
  output logic              accWrStb,
  input  logic              pinLevel,
  output logic              pullDownEn,
  output logic              sleepEn,
  output logic              altOpSel
);
  ctlStrb_t         strb;
  logic [CNT_W-1:0] bitIdx;

  regAccCtl uCtl (
    .clk      (clk),
    .rstN     (rstN),
    .busReset (busReset),
    .selDone  (selDone),
    .bitValid (bitValid),
    .bitIn    (bitIn),
    .strb     (strb),
    .bitIdx   (bitIdx)
  );

  regAccData #(
    .STAT_ADDR   (STAT_ADDR),
    .PINC_ADDR   (PINC_ADDR),
    .CUR_HI_ADDR (CUR_HI_ADDR),
    .CUR_LO_ADDR (CUR_LO_ADDR),
    .ACC_HI_ADDR (ACC_HI_ADDR),
    .ACC_LO_ADDR (ACC_LO_ADDR)
  ) uData (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .bitIdx     (bitIdx),
    .bitIn      (bitIn),
    .curValue   (curValue),
    .accValue   (accValue),
    .pinLevel   (pinLevel),
    .bitOut     (bitOut),
    .sleepEn    (sleepEn),
    .altOpSel   (altOpSel),
    .pullDownEn (pullDownEn),
    .accWrData  (accWrData),
    .accWrStb   (accWrStb)
  );
endmodule

// File: tb/regAccessCtl_test.sv
`timescale 1ns/1ps
module regAccessCtl_test;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busReset = 1'b0;
  logic        selDone = 1'b0;
  logic        bitValid = 1'b0;
  logic        bitIn = 1'b0;
  logic        bitOut;
  logic [15:0] curValue = 16'h0000;
  logic [15:0] accValue = 16'h0000;
  logic [15:0] accWrData;
  logic        accWrStb;
  logic        pinLevel = 1'b0;
  logic        pullDownEn;
  logic        sleepEn;
  logic        altOpSel;

  int nChk = 0;
  int nBad = 0;
  logic cmpOn = 1'b0;

  // behavioural model state
  logic        expSleep = 1'b0;
  logic        expAlt = 1'b0;
  logic        expPd = 1'b0;
  logic        expStb = 1'b0;
  logic [15:0] expData = 16'h0000;
  logic [7:0]  mAccHi = 8'h00;
  logic [15:0] curSnap, accSnap;
  logic        curSnapV = 1'b0, accSnapV = 1'b0;

  regAccessCtl uut (
    .clk(clk), .rstN(rstN), .busReset(busReset), .selDone(selDone),
    .bitValid(bitValid), .bitIn(bitIn), .bitOut(bitOut),
    .curValue(curValue), .accValue(accValue), .accWrData(accWrData),
    .accWrStb(accWrStb), .pinLevel(pinLevel), .pullDownEn(pullDownEn),
    .sleepEn(sleepEn), .altOpSel(altOpSel)
  );

  always #(CLK_P/2) clk = ~clk;

  task automatic check(input logic ok, input string req, input logic [15:0] act,
                       input logic [15:0] exp);
    nChk++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // per-clock comparison of the persistent outputs
  always begin
    @(posedge clk);
    #(CLK_P/4);
    if (cmpOn) begin
      check(sleepEn == expSleep, "R5 sleepEn", 16'(sleepEn), 16'(expSleep));
      check(altOpSel == expAlt, "R5 altOpSel", 16'(altOpSel), 16'(expAlt));
      check(pullDownEn == expPd, "R6 pullDownEn", 16'(pullDownEn), 16'(expPd));
      check(accWrStb == expStb, "R7/R8 accWrStb", 16'(accWrStb), 16'(expStb));
      check(accWrData == expData, "R7 accWrData", accWrData, expData);
    end
  end

  function automatic logic [7:0] modelRead(input logic [7:0] a);
    logic [7:0] r = 8'h00;
    case (a)
      8'h01: begin r[6] = expSleep; r[4] = expAlt; end
      8'h08: r[6] = pinLevel;
      8'h0E: r = curSnap[15:8];
      8'h0F: r = curSnapV ? curSnap[7:0] : curValue[7:0];
      8'h10: r = accSnap[15:8];
      8'h11: r = accSnapV ? accSnap[7:0] : accValue[7:0];
      default: r = 8'h00;
    endcase
    return r;
  endfunction

  task automatic applyWrite(input logic [7:0] a, input logic [7:0] v);
    case (a)
      8'h01: begin expSleep = v[6]; expAlt = v[4]; end
      8'h08: expPd = !v[6];
      8'h10: mAccHi = v;
      8'h11: begin expData = {mAccHi, v}; expStb = 1'b1; end
      default: ;
    endcase
  endtask

  task automatic doBit(input logic b);
    bitValid = 1'b1;
    bitIn = b;
    @(negedge clk);
    bitValid = 1'b0;
    expStb = 1'b0;
  endtask

  task automatic sendByte(input logic [7:0] v);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      doBit(v[i]);
    end
  endtask

  task automatic startCmd(input logic [7:0] op, input logic [7:0] a);
    @(negedge clk);
    selDone = 1'b1;
    curSnapV = 1'b0;
    accSnapV = 1'b0;
    @(negedge clk);
    selDone = 1'b0;
    sendByte(op);
    sendByte(a);
  endtask

  task automatic writeByte(input logic [7:0] a, input logic [7:0] v);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (i == 7) applyWrite(a, v);
      doBit(v[i]);
    end
  endtask

  task automatic readByte(input logic [7:0] a, input string req);
    logic [7:0] e;
    if (a == 8'h0E) begin curSnap = curValue; curSnapV = 1'b1; end
    if (a == 8'h10) begin accSnap = accValue; accSnapV = 1'b1; end
    e = modelRead(a);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      check(bitOut == e[i], req, 16'(bitOut), 16'(e[i]));
      doBit(1'b1);
    end
  endtask

  task automatic pulseBusReset();
    @(negedge clk);
    busReset = 1'b1;
    @(negedge clk);
    busReset = 1'b0;
  endtask

  initial begin
    #(CLK_P * 200000);
    nBad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    cmpOn = 1'b1;
    // reset state (R5, R6)
    check(sleepEn == 1'b0 && altOpSel == 1'b0, "R5 reset status", 16'({sleepEn, altOpSel}), 16'h0);
    check(pullDownEn == 1'b0, "R6 reset pull-down", 16'(pullDownEn), 16'h0);
    check(bitOut == 1'b0, "R1 idle bitOut", 16'(bitOut), 16'h0);

    // R5: status write, then R3/R2 readback across 00h and 01h
    startCmd(8'h6C, 8'h01);
    writeByte(8'h01, 8'h50);
    startCmd(8'h69, 8'h00);
    readByte(8'h00, "R3 reserved 00h");
    readByte(8'h01, "R2 R3 status after increment");

    // R6: pin control, and pin level readback
    startCmd(8'h6C, 8'h08);
    writeByte(8'h08, 8'h00);
    pinLevel = 1'b0;
    startCmd(8'h69, 8'h08);
    readByte(8'h08, "R6 pin low");
    pinLevel = 1'b1;
    readByte(8'h09, "R3 reserved 09h");
    startCmd(8'h69, 8'h08);
    readByte(8'h08, "R6 pin high");
    startCmd(8'h6C, 8'h08);
    writeByte(8'h08, 8'hFF);

    // R8 then R7: read-only bytes ignored, accumulator committed
    curValue = 16'h1357;
    startCmd(8'h6C, 8'h0E);
    writeByte(8'h0E, 8'hAA);
    writeByte(8'h0F, 8'h55);
    writeByte(8'h10, 8'h12);
    writeByte(8'h11, 8'h34);
    startCmd(8'h69, 8'h0E);
    readByte(8'h0E, "R8 current unchanged high");

    // R4: coherent pair reads
    curValue = 16'hA55A;
    accValue = 16'hC3E1;
    startCmd(8'h69, 8'h0E);
    readByte(8'h0E, "R4 current high");
    curValue = 16'h0FF0;
    readByte(8'h0F, "R4 current low captured");
    readByte(8'h10, "R4 acc high");
    accValue = 16'h7788;
    readByte(8'h11, "R4 acc low captured");
    startCmd(8'h69, 8'h0F);
    readByte(8'h0F, "R4 live low without high read");
    readByte(8'h10, "R4 acc high second");

    // R2: wrap on write and on read
    startCmd(8'h6C, 8'hFF);
    writeByte(8'hFF, 8'h50);
    writeByte(8'h00, 8'h50);
    writeByte(8'h01, 8'h10);
    startCmd(8'h69, 8'hFF);
    readByte(8'hFF, "R2 reserved FFh");
    readByte(8'h00, "R2 wrap 00h");
    readByte(8'h01, "R2 wrap status");

    // R9: partial write aborted by bus reset
    startCmd(8'h6C, 8'h01);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      doBit(1'b1);
    end
    pulseBusReset();
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      doBit(1'b1);
    end
    startCmd(8'h69, 8'h01);
    readByte(8'h01, "R9 status kept after partial byte");

    // R9: read cut after three bits, then a fresh command
    startCmd(8'h69, 8'h01);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      doBit(1'b1);
    end
    pulseBusReset();
    @(negedge clk);
    check(bitOut == 1'b0, "R9 bitOut after bus reset", 16'(bitOut), 16'h0);
    startCmd(8'h69, 8'h11);
    readByte(8'h11, "R9 fresh read after abort");

    // R1: unknown command ignored
    startCmd(8'hAA, 8'h01);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      check(bitOut == 1'b0, "R1 unknown command bitOut", 16'(bitOut), 16'h0);
      doBit(1'b0);
    end

    repeat (3) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end
endmodule